// File: doc/BRIEF.md
# Asynchronous Serial Character Receiver

This block takes a serial line that rests at logic high and recovers framed characters from it. A sampling enable, `tick`, pulses sixteen times per bit period. The receiver watches the line on each tick for a change from high to low. When it sees one, it waits until the middle of the start bit and checks that the line is still low. A short low pulse that has already ended by then is thrown away, and the receiver goes back to watching for an edge. Once the start bit is confirmed, the receiver samples the data bits, the optional parity bit and the first stop bit, each one near its centre. The finished character is then copied into a receive buffer register.

The character format comes from three inputs: the word length (five to eight bits), parity on or off, and even or odd parity. These inputs should only change between characters. Four status flags report the receiver's condition: data ready, overrun, parity error and framing error. A host reads the buffer with a one-cycle `rbr_rd` pulse and reads the status with a one-cycle `lsr_rd` pulse. The block does not include the tick generator, any interrupt logic or a FIFO.

Top module: `uart_rx_core`

## Requirements
- R1: After reset, all four flags are 0, `rbr` is 0, and the receiver is searching for a start edge.
- R2: A start edge is a tick where the line is low and the line was high on the previous tick. On the seventh tick after the detecting tick, the line is sampled again. If the line is high there, nothing is assembled and no output changes. A low pulse lasting 1 to 7 ticks therefore has no effect.
- R3: Data bits are received LSB first. `word_len` selects the length: 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8. Buffer bits above the word length read as 0. `rbr` changes only when a character is loaded.
- R4: When `par_en` is 1, one parity bit follows the last data bit. With `par_even` = 1, the data bits plus the parity bit must contain an even number of ones; with `par_even` = 0, an odd number. A mismatch sets `parity_err`. When `par_en` is 0, no parity bit is expected and `parity_err` is never set.
- R5: If the line is low when the first stop bit is sampled, `framing_err` is set and the character is still loaded. The receiver then goes straight back to edge search, so a new start bit needs the line to have been high on an earlier tick.
- R6: Loading a character sets `data_ready`, and an `rbr_rd` pulse clears it. If a load and a read happen in the same cycle, `data_ready` ends up 1.
- R7: `overrun` is set when a character is loaded while `data_ready` is 1, unless `rbr_rd` is also asserted in that same cycle. The new character replaces the old one in the buffer.
- R8: `overrun`, `parity_err` and `framing_err` stay set until an `lsr_rd` pulse clears them. If a flag is set by a load in the same cycle as `lsr_rd`, the flag ends up 1.
- R9: Each data, parity and stop bit is sampled 16 ticks after the previous sample. For a start edge detected at start-bit tick 0, the load takes effect on the clock edge of stop-bit tick 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Sampling enable, 16 per bit |
| rxd | input | 1 | Serial line, idles high |
| word_len | input | 2 | Data length code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 selects even parity, 0 selects odd |
| rbr_rd | input | 1 | Buffer read strobe |
| lsr_rd | input | 1 | Status read strobe |
| rbr | output | 8 | Receive buffer |
| data_ready | output | 1 | Unread character present |
| overrun | output | 1 | Character lost to overwrite |
| parity_err | output | 1 | Parity mismatch seen |
| framing_err | output | 1 | Stop bit sampled low |

## Verification
Two events can happen in the same cycle: a character load and a host read. There are two such pairs. A buffer read can land on a load, which affects `data_ready` and `overrun`. A status read can land on a load that raises an error flag.
The bench drives the tick itself, so it knows exactly which clock edge carries the stop-bit sample. It places the read strobe on that edge in directed cases and in randomly chosen frames. A reference model then computes the result using the rule that a set wins over a clear, and the bench compares the model's flags with the port values right after that edge.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       rbr_rd,
  input  logic       lsr_rd,
  output logic [7:0] rbr,
  output logic       data_ready,
  output logic       overrun,
  output logic       parity_err,
  output logic       framing_err
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] BIT_END = CW'(OSR - 1);
  localparam logic [CW-1:0] START_END = CW'(OSR / 2 - 2);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;
  logic          prev, par_acc, perr_q;

  wire [2:0] last_idx = 3'd4 + {1'b0, word_len};
  wire mid      = tick && (cnt == BIT_END);
  wire half     = tick && (cnt == START_END);
  wire fall     = tick && prev && !rxd;
  wire par_bad  = par_even ? (par_acc ^ rxd) : ~(par_acc ^ rxd);
  wire load     = (st == S_STOP) && mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      idx <= '0;
      shreg <= '0;
      prev <= 1'b1;
      par_acc <= 1'b0;
      perr_q <= 1'b0;
    end else begin
      if (tick) prev <= rxd;
      case (st)
        S_IDLE:
          if (fall) begin
            st <= S_START;
            cnt <= '0;
          end
        S_START:
          if (tick) begin
            if (half) begin
              cnt <= '0;
              if (!rxd) begin
                st <= S_DATA;
                idx <= '0;
                shreg <= '0;
                par_acc <= 1'b0;
                perr_q <= 1'b0;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_DATA:
          if (tick) begin
            cnt <= mid ? '0 : cnt + 1'b1;
            if (mid) begin
              shreg[idx] <= rxd;
              par_acc <= par_acc ^ rxd;
              idx <= idx + 3'd1;
              if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
            end
          end
        S_PAR:
          if (tick) begin
            cnt <= mid ? '0 : cnt + 1'b1;
            if (mid) begin
              perr_q <= par_bad;
              st <= S_STOP;
            end
          end
        S_STOP:
          if (tick) begin
            cnt <= mid ? '0 : cnt + 1'b1;
            if (mid) st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr <= '0;
      data_ready <= 1'b0;
      overrun <= 1'b0;
      parity_err <= 1'b0;
      framing_err <= 1'b0;
    end else begin
      if (load) rbr <= shreg;
      data_ready  <= load | (data_ready & ~rbr_rd);
      overrun     <= (load & data_ready & ~rbr_rd) | (overrun & ~lsr_rd);
      parity_err  <= (load & perr_q) | (parity_err & ~lsr_rd);
      framing_err <= (load & ~rxd) | (framing_err & ~lsr_rd);
    end
  end
endmodule

// File: rtl/uart_rx_core_sva.sv
module uart_rx_core_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       rbr_rd,
  input logic       lsr_rd,
  input logic       par_en,
  input logic [1:0] word_len,
  input logic       load,
  input logic [7:0] rbr,
  input logic       data_ready,
  input logic       overrun,
  input logic       parity_err,
  input logic       framing_err
);
  assert_rbr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(rbr));
  assert_short_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && word_len == 2'd0) |=> (rbr[7:5] == 3'd0));
  assert_pe_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(parity_err) |-> par_en);
  assert_dr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_ready && !rbr_rd) |=> data_ready);
  assert_overrun_needs_dr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> data_ready);
  assert_flags_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !load) |=> !(overrun || parity_err || framing_err));
  assert_pe_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (parity_err && !lsr_rd) |=> parity_err);
endmodule

bind uart_rx_core uart_rx_core_sva u_sva (.*);

// File: tb/tb_uart_rx_core.sv
module tb_uart_rx_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic par_en = 1'b0, par_even = 1'b0, rbr_rd = 1'b0, lsr_rd = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic [7:0] rbr;
  logic data_ready, overrun, parity_err, framing_err;

  int n_chk = 0, n_bad = 0;
  logic m_dr = 0, m_oe = 0, m_pe = 0, m_fe = 0;
  logic [7:0] m_rbr = 0;

  uart_rx_core dut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] wmask(logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  function automatic logic par_bit(logic [7:0] d, logic [1:0] wl, logic even);
    return (^(d & wmask(wl))) ^ ~even;
  endfunction

  task automatic check_all(string ctx);
    chk({"R3 rbr ", ctx}, rbr, m_rbr);
    chk({"R6 data_ready ", ctx}, {7'd0, data_ready}, {7'd0, m_dr});
    chk({"R7 overrun ", ctx}, {7'd0, overrun}, {7'd0, m_oe});
    chk({"R4 parity_err ", ctx}, {7'd0, parity_err}, {7'd0, m_pe});
    chk({"R5 framing_err ", ctx}, {7'd0, framing_err}, {7'd0, m_fe});
  endtask

  task automatic tk(logic v, logic rd, logic ls);
    @(negedge clk);
    tick = 1'b1; rxd = v; rbr_rd = rd; lsr_rd = ls;
    @(negedge clk);
    tick = 1'b0; rbr_rd = 1'b0; lsr_rd = 1'b0;
  endtask

  task automatic bit_ticks(logic v);
    for (int t = 0; t < 16; t++) tk(v, 1'b0, 1'b0);
  endtask

  task automatic frame(logic [7:0] d, logic bad_par, logic stop_v, logic rd_ld, logic ls_ld);
    logic [7:0] dm;
    logic dr0, oe_new;
    dm = d & wmask(word_len);
    dr0 = m_dr;
    bit_ticks(1'b0);
    for (int b = 0; b < 5 + int'(word_len); b++) bit_ticks(d[b]);
    if (par_en) bit_ticks(par_bit(d, word_len, par_even) ^ bad_par);
    for (int t = 0; t < 16; t++) begin
      tk(stop_v, (t == 7) && rd_ld, (t == 7) && ls_ld);
      if (t == 6) chk("R9 no load before stop centre", {7'd0, data_ready}, {7'd0, dr0});
      if (t == 7) begin
        oe_new = m_dr & ~rd_ld;
        m_dr = 1'b1;
        m_oe = oe_new | (m_oe & ~ls_ld);
        m_pe = (par_en & bad_par) | (m_pe & ~ls_ld);
        m_fe = ~stop_v | (m_fe & ~ls_ld);
        m_rbr = dm;
        chk("R9 load at stop centre", rbr, dm);
        check_all("after load");
      end
    end
    for (int t = 0; t < 4; t++) tk(1'b1, 1'b0, 1'b0);
  endtask

  task automatic rd_rbr();
    @(negedge clk); rbr_rd = 1'b1;
    @(negedge clk); rbr_rd = 1'b0;
    m_dr = 1'b0;
    chk("R6 cleared by buffer read", {7'd0, data_ready}, 8'd0);
  endtask

  task automatic rd_lsr();
    @(negedge clk); lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0;
    m_oe = 0; m_pe = 0; m_fe = 0;
    check_all("R8 after status read");
  endtask

  task automatic glitch(int len);
    for (int t = 0; t < len; t++) tk(1'b0, 1'b0, 1'b0);
    for (int t = 0; t < 24; t++) tk(1'b1, 1'b0, 1'b0);
    check_all("R2 glitch rejected");
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_all("R1 reset state");
    rst_n = 1'b1;
    for (int t = 0; t < 4; t++) tk(1'b1, 1'b0, 1'b0);

    word_len = 2'd3; par_en = 0;
    frame(8'hA5, 0, 1, 0, 0);               // R3 8-bit
    rd_rbr();
    word_len = 2'd0;
    frame(8'hFF, 0, 1, 0, 0);               // R3 5-bit, upper bits zero
    rd_rbr();
    par_en = 1; par_even = 1; word_len = 2'd3;
    frame(8'h3C, 0, 1, 0, 0);               // R4 even ok
    rd_rbr();
    frame(8'h3C, 1, 1, 0, 0);               // R4 even bad
    rd_rbr(); rd_lsr();
    par_even = 0; word_len = 2'd2;
    frame(8'h51, 1, 1, 0, 0);               // R4 odd bad
    rd_rbr(); rd_lsr();
    par_en = 0;
    frame(8'h12, 0, 0, 0, 0);               // R5 framing
    frame(8'h34, 0, 1, 0, 0);               // R5 next frame after low stop; R7 overrun
    rd_rbr(); rd_lsr();
    frame(8'h77, 0, 1, 0, 0);
    frame(8'h78, 0, 1, 1, 0);               // R6/R7 read at load: no overrun
    rd_rbr();
    frame(8'h99, 0, 0, 0, 1);               // R8 set wins over status read
    rd_rbr(); rd_lsr();
    for (int g = 1; g <= 7; g++) glitch(g); // R2

    for (int i = 0; i < 100; i++) begin
      word_len = 2'($urandom_range(0, 3));
      par_en = 1'($urandom_range(0, 1));
      par_even = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 3) != 0) rd_rbr();
      if ($urandom_range(0, 1) != 0) rd_lsr();
      if ($urandom_range(0, 9) == 0) glitch($urandom_range(1, 7));
      frame(8'($urandom), $urandom_range(0, 7) == 0, $urandom_range(0, 7) != 0,
            $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule